// File: doc/BRIEF.md
# Four-Beat Double-Rate SRAM Write Port

This block is the write side of a separate-I/O synchronous SRAM whose writes always move a fixed burst of four words. A write command and its burst address are taken on a rising edge of the main clock. The four data words follow one main cycle later. They arrive at double rate: the first and third on main-clock rising edges, the second and fourth on the rising edges of the complementary clock. Every word carries its own active-low byte-write mask. Each completed word is committed to an on-chip storage array, and a registered read port lets the surrounding logic, or a test bench, see what the array holds.

Both clock phases are modelled as consecutive rising edges of a single double-rate clock `clk`. After reset, a free-running two-bit phase counter numbers these edges 0, 1, 2 and 3. Edges 0 and 2 are main-clock edges, and edges 1 and 3 are complementary-clock edges. Main-clock edges take turns between write slots (phase 0) and read slots (phase 2). A write command is therefore accepted once every two main cycles at most. A command offered in a read slot is dropped, and a one-cycle error flag is raised. `wr_window` tells the host that the next edge is a write slot.

Top module: `qb4_write_port`

## Requirements
- R1: While `rst` is high, and after it is released, `rd_data` and `slot_err` are 0 and `wr_window` is 1. The first `clk` edge with `rst` low is phase 0, so a command there is accepted. A reset in mid-run restarts this numbering.
- R2: `wr_en` is sampled only at phase 0, where the burst address `wr_addr` is taken with it. `wr_window` is high exactly when the coming edge is phase 0.
- R3: For a command accepted at edge n, data words 0, 1, 2 and 3 are sampled at edges n+2, n+3, n+4 and n+5. Word b is stored at array index `{wr_addr, b}`, with b in the two low bits.
- R4: `wr_bw_n` bit i (1 = blocked) guards lane i, which is `wr_data[9i+8:9i]`. It is sampled with each data word. A blocked lane leaves that lane of that word unchanged, and the other lanes of the word are written.
- R5: `wr_en` high at phase 2 is ignored: no word is written. `slot_err` is then high for exactly the following cycle. `wr_en` at phases 1 and 3 is ignored without an error.
- R6: Commands on every phase-0 edge (one every four `clk` edges) all complete. The third and fourth words of one burst overlap the command of the next burst.
- R7: `rd_data` shows the array word at `rd_addr` one cycle after the edge that samples `rd_addr`. A word committed from a data sample at edge m is visible to a read sampled at edge m+2 or later.
- R8: `wr_data` and `wr_bw_n` have no effect at edges that fall outside the four data edges of an accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; its edges stand for main and complementary clock edges in turn |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write command request |
| wr_addr | input | ADDR_W | Burst address of the command |
| wr_data | input | DATA_W | Double-rate write data word |
| wr_bw_n | input | DATA_W/9 | Active-low lane write mask for the current word |
| rd_addr | input | ADDR_W+2 | Array word index to read |
| rd_data | output | DATA_W | Registered array word |
| wr_window | output | 1 | High when the next edge is a write slot |
| slot_err | output | 1 | One-cycle pulse after a command offered in a read slot |

## Verification
On every cycle, the assertions check the following:
- a burst starts only from a command taken two edges earlier;
- its first word is sampled on a phase-2 edge;
- the words of a burst run in order without gaps and keep one burst address;
- the error flag never lasts more than one cycle.

Only the bench scenarios can show whether the right values reach the right words. These cover lane masking that preserves old contents, back-to-back bursts, commands dropped in read slots, junk data between bursts, and command acceptance right after a mid-run reset. The bench shows this by comparing every read with a behavioural model of the array.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  localparam int LANE_W = 9;
  localparam int BEATS  = 4;

  // Edge numbering of the double-rate clock; 0 and 2 are main-clock edges.
  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,  // main edge, write slot, word 2 of a running burst
    PH_HALF1 = 2'd1,  // complementary edge, word 3
    PH_DATA  = 2'd2,  // main edge, read slot, word 0
    PH_HALF3 = 2'd3   // complementary edge, word 1
  } phase_e;
endpackage

// File: rtl/qb4_phase.sv
module qb4_phase
  import qb4_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_CMD;
    else     phase <= phase_e'(phase + 2'd1);
  end
endmodule

// File: rtl/qb4_cmd.sv
module qb4_cmd
  import qb4_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              pend,
  output logic [ADDR_W-1:0] pend_addr,
  output logic              slot_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      slot_err <= 1'b0;
    end else begin
      if (phase == PH_CMD) begin
        pend <= wr_en;
        if (wr_en) pend_addr <= wr_addr;
      end
      slot_err <= wr_en && (phase == PH_DATA);
    end
  end

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    slot_err |=> !slot_err); // R5
endmodule

// File: rtl/qb4_beat.sv
module qb4_beat
  import qb4_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18,
  localparam int LANES = DATA_W / LANE_W,
  localparam int WA_W  = ADDR_W + $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic              pend,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_bw_n,
  output logic              cap_vld,
  output logic [WA_W-1:0]   cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic [LANES-1:0]  lane_we
);
  logic              burst_act;
  logic [ADDR_W-1:0] burst_addr;
  logic              take;
  logic [ADDR_W-1:0] take_addr;
  logic [LANES-1:0]  cap_bwn;

  // The first word of a burst comes straight from the command register;
  // the rest use the copy held for the whole burst.
  always_comb begin
    if (phase == PH_DATA) begin
      take      = pend;
      take_addr = pend_addr;
    end else begin
      take      = burst_act;
      take_addr = burst_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_act <= 1'b0;
      cap_vld   <= 1'b0;
    end else begin
      if (phase == PH_DATA) begin
        burst_act  <= pend;
        burst_addr <= pend_addr;
      end
      cap_vld  <= take;
      cap_addr <= {take_addr, phase ^ 2'b10};
      cap_data <= wr_data;
      cap_bwn  <= wr_bw_n;
    end
  end

  always_comb lane_we = cap_vld ? ~cap_bwn : '0;

  AST_FIRST_WORD_SLOT: assert property (@(posedge clk) disable iff (rst)
    (cap_vld && cap_addr[1:0] == 2'd0) |-> $past(phase) == PH_DATA); // R3
  AST_WORDS_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (cap_vld && cap_addr[1:0] != 2'd3) |=>
      (cap_vld && cap_addr[1:0] == 2'($past(cap_addr[1:0]) + 2'd1)
       && cap_addr[WA_W-1:2] == $past(cap_addr[WA_W-1:2]))); // R3
endmodule

// File: rtl/qb4_lane_ram.sv
module qb4_lane_ram #(
  parameter int AW = 6,
  parameter int W  = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/qb4_write_port.sv
module qb4_write_port
  import qb4_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18,
  localparam int LANES = DATA_W / LANE_W,
  localparam int WA_W  = ADDR_W + $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_bw_n,
  input  logic [WA_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_window,
  output logic              slot_err
);
  phase_e              phase;
  logic                pend;
  logic [ADDR_W-1:0]   pend_addr;
  logic                cap_vld;
  logic [WA_W-1:0]     cap_addr;
  logic [DATA_W-1:0]   cap_data;
  logic [LANES-1:0]    lane_we;

  qb4_phase u_phase (.clk(clk), .rst(rst), .phase(phase));

  qb4_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .phase(phase), .wr_en(wr_en), .wr_addr(wr_addr),
    .pend(pend), .pend_addr(pend_addr), .slot_err(slot_err)
  );

  qb4_beat #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_beat (
    .clk(clk), .rst(rst), .phase(phase), .pend(pend), .pend_addr(pend_addr),
    .wr_data(wr_data), .wr_bw_n(wr_bw_n), .cap_vld(cap_vld),
    .cap_addr(cap_addr), .cap_data(cap_data), .lane_we(lane_we)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    qb4_lane_ram #(.AW(WA_W), .W(LANE_W)) u_ram (
      .clk(clk), .rst(rst), .we(lane_we[i]), .waddr(cap_addr),
      .wdata(cap_data[i*LANE_W +: LANE_W]), .raddr(rd_addr),
      .rdata(rd_data[i*LANE_W +: LANE_W])
    );
  end

  assign wr_window = (phase == PH_CMD);

  AST_BURST_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    (pend && phase == PH_DATA) |-> $past(wr_en, 2)); // R2
  AST_WRITE_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    (lane_we != '0) |-> cap_vld); // R8
endmodule

// File: tb/qb4_write_port_bench.sv
module qb4_write_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 18;
  localparam int LANES  = DATA_W / 9;
  localparam int WA_W   = ADDR_W + 2;
  localparam int WORDS  = 1 << WA_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [LANES-1:0]  wr_bw_n = '1;
  logic [WA_W-1:0]   rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              wr_window;
  logic              slot_err;

  qb4_write_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qb4_write_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bw_n(wr_bw_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_window(wr_window), .slot_err(slot_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";

  // behavioural model state
  logic [DATA_W-1:0] refmem [WORDS];
  logic [DATA_W-1:0] known  [WORDS];
  int                q_start[$];
  int                q_addr[$];
  int                k = 0;
  int                cur_start = 0;
  int                cur_addr = 0;
  bit                cur_v = 0;
  bit                have_cap = 0;
  int                cap_word = 0;
  logic [DATA_W-1:0] cap_d;
  logic [LANES-1:0]  cap_m;
  logic [DATA_W-1:0] exp_rd, exp_known;
  bit                exp_err, exp_win;

  task automatic model_edge();
    exp_rd    = refmem[rd_addr];
    exp_known = known[rd_addr];
    if (have_cap) begin
      for (int l = 0; l < LANES; l++)
        if (!cap_m[l]) begin
          refmem[cap_word][l*9 +: 9] = cap_d[l*9 +: 9];
          known[cap_word][l*9 +: 9]  = '1;
        end
    end
    have_cap = 0;
    exp_err = wr_en && (k % 4 == 2);
    if (wr_en && (k % 4 == 0)) begin
      q_start.push_back(k + 2);
      q_addr.push_back(int'(wr_addr));
    end
    if (q_start.size() > 0 && q_start[0] == k) begin
      cur_start = q_start.pop_front();
      cur_addr  = q_addr.pop_front();
      cur_v = 1;
    end
    if (cur_v && (k - cur_start) < 4) begin
      cap_word = cur_addr * 4 + (k - cur_start);
      cap_d = wr_data;
      cap_m = wr_bw_n;
      have_cap = 1;
    end
    exp_win = ((k + 1) % 4 == 0);
    k++;
  endtask

  task automatic compare();
    compared++;
    if ((rd_data & exp_known) !== (exp_rd & exp_known)) begin
      mismatched++;
      $display("FAIL R7 (%s) rd_addr=%0d actual=%h expected=%h known=%h",
               tag, rd_addr, rd_data, exp_rd, exp_known);
    end
    compared++;
    if (slot_err !== exp_err) begin
      mismatched++;
      $display("FAIL R5 (%s) slot_err actual=%b expected=%b k=%0d", tag, slot_err, exp_err, k);
    end
    compared++;
    if (wr_window !== exp_win) begin
      mismatched++;
      $display("FAIL R2 (%s) wr_window actual=%b expected=%b k=%0d", tag, wr_window, exp_win, k);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      compared++;
      if (rd_data !== '0 || slot_err !== 1'b0 || wr_window !== 1'b1) begin
        mismatched++;
        $display("FAIL R1 reset state actual rd=%h err=%b win=%b expected rd=0 err=0 win=1",
                 rd_data, slot_err, wr_window);
      end
    end
    rst = 1'b0;
    k = 0; cur_v = 0; have_cap = 0;
    q_start.delete(); q_addr.delete();
  endtask

  task automatic align();
    wr_en = 1'b0;
    while (k % 4 != 0) tick();
  endtask

  // nb commands on consecutive write slots; junk data with open masks elsewhere
  task automatic run_bursts(int nb, int base, int maskmode, int seed);
    align();
    for (int t = 0; t < 4 * nb + 4; t++) begin
      int j, b;
      wr_en   = (t % 4 == 0) && (t < 4 * nb);
      wr_addr = ADDR_W'(base + t / 4);
      j = (t - 2) / 4;
      b = (t - 2) % 4;
      if (t >= 2 && j < nb) begin
        wr_data = DATA_W'((base + j) * 37 + b * 11 + seed * 101);
        wr_bw_n = (maskmode != 0) ? LANES'((j + b) % (1 << LANES)) : '0;
      end else begin
        wr_data = DATA_W'(k * 7 + 5);
        wr_bw_n = '0;
      end
      rd_addr = WA_W'(t);
      tick();
    end
    wr_en = 1'b0;
  endtask

  task automatic read_back(int first, int count);
    for (int w = first; w < first + count + 1; w++) begin
      rd_addr = WA_W'(w % WORDS);
      wr_data = DATA_W'(w * 13);
      tick();
    end
  endtask

  initial begin
    for (int w = 0; w < WORDS; w++) begin
      refmem[w] = '0;
      known[w]  = '0;
    end
    tag = "R1";
    do_reset();
    tag = "R2 R3 R8";
    run_bursts(1, 3, 0, 1);
    read_back(12, 4);
    tag = "R6";
    run_bursts(4, 0, 0, 2);
    read_back(0, 16);
    tag = "R4";
    run_bursts(4, 0, 1, 3);
    read_back(0, 16);
    tag = "R5";
    run_bursts(1, 12, 0, 4);
    align();
    for (int t = 0; t < 16; t++) begin
      wr_en   = (t % 4 != 0);
      wr_addr = ADDR_W'(12);
      wr_data = DATA_W'(t * 3 + 1);
      wr_bw_n = '0;
      tick();
    end
    wr_en = 1'b0;
    for (int t = 0; t < 6; t++) tick();
    read_back(48, 4);
    tag = "R1";
    do_reset();
    wr_en = 1'b1; wr_addr = ADDR_W'(9);
    tick();
    wr_en = 1'b0;
    for (int b = 0; b < 5; b++) begin
      wr_data = DATA_W'(18'h2A5A5 + b);
      wr_bw_n = '0;
      tick();
    end
    for (int t = 0; t < 3; t++) tick();
    read_back(36, 4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule